// File: doc/BRIEF.md
# Sample Clock Phase Tuning Controller

This controller searches for a usable receive sampling phase on a storage-card host interface. A start pulse begins a sweep over a set of evenly spaced sample-clock phases, taken in rising index order. The default is eight phases of 45 degrees each, so index k means k*45 degrees. For each phase the controller does three things in turn. It sends the phase index to an external phase shifter. It writes an all-ones clear mask to the interrupt status. It asks an external command engine for one tuning transfer and records the pass or fail result that comes back.

While the sweep runs, the controller notes where a run of passing phases begins (the rising edge) and where it ends (the falling edge). It stops as soon as it has seen both. It then picks a phase near the centre of the passing window, including a window that wraps from the last phase back to index 0. It applies that phase, clears the interrupt status once more and reports done. If no phase passed, it applies no phase and flags an error together with done.

Top module: `samp_phase_tuner`

## Requirements
- R1: After reset, and while idle, busy_o, done_o, err_o, phase_vld_o, clr_we_o and tune_req_o are all low.
- R2: After a start pulse in idle, the sweep begins at index 0 and steps up by one. For each index the output sequence is a one-cycle phase_vld_o carrying that index on phase_idx_o, then a one-cycle clr_we_o with clr_data_o all ones (17 bits, 0x1FFFF), then tune_req_o. The three never overlap.
- R3: tune_req_o stays high until a cycle with tune_ack_i high. tune_pass_i is sampled in that cycle, 1 meaning the transfer passed.
- R4: Edges are looked for only from index 1 upward. A fail that follows a pass sets the fall point to the previous index. A pass that follows a fail sets the raise point to the current index.
- R5: Once both a raise point and a fall point are recorded, no further transfer is requested and the sweep ends. Otherwise it ends after the last index.
- R6: If any index passed, a missing raise point counts as 0 and a missing fall point counts as the last index. When fall >= raise, the chosen index is floor((raise+fall)/2).
- R7: When fall < raise (a wrapped window), the chosen index is floor(fall/2) if raise+fall is greater than the last index. Otherwise it is floor((raise+last)/2).
- R8: If no index passed, no final phase strobe is issued, and err_o is high during the done cycle. err_o is never high outside the done cycle.
- R9: Every sweep ends with a final phase strobe (only if something passed), then one clear write, then a one-cycle done_o. busy_o is high from the cycle after start through the done cycle, and low after it.
- R10: A start pulse that arrives while busy_o is high is ignored. Raise, fall and found state are cleared at each accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a tuning sweep (accepted when idle) |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle end-of-sweep pulse |
| err_o | output | 1 | With done_o: no phase passed |
| phase_idx_o | output | 3 | Phase index to apply, valid with phase_vld_o |
| phase_vld_o | output | 1 | One-cycle phase apply strobe |
| clr_we_o | output | 1 | One-cycle interrupt status clear write |
| clr_data_o | output | 17 | Clear mask, all ones |
| tune_req_o | output | 1 | Tuning transfer request, held until acknowledged |
| tune_ack_i | input | 1 | Tuning transfer finished |
| tune_pass_i | input | 1 | Transfer result, 1 = pass, sampled with tune_ack_i |

## Verification
The assertions check, on every cycle, the local handshake and strobe rules. These are: a clear write right before each new request, the request held until acknowledged, no two strobes together, the clear mask being all ones, done lasting one cycle, err only during done, and a start while busy having no effect on busy. Only the bench scenarios can show that the edge rules, the early stop and the centre-pick rules give the right phases and the right number of transfers. To do this, the bench compares the full event order against a model for plain, wrapped, single-pass, all-pass and all-fail patterns, with varied acknowledge latency.

// File: rtl/spt_pkg.sv
package spt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PHASE,
      ST_CLR,
      ST_REQ,
      ST_CHECK,
      ST_APPLY,
      ST_ENDCLR,
      ST_DONE
   } spt_state_e;

endpackage

// File: rtl/spt_edge_track.sv
module spt_edge_track #(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             upd_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic             pass_i,
   output logic             found_o,
   output logic             raise_set_o,
   output logic [IDX_W-1:0] raise_o,
   output logic             fall_set_o,
   output logic [IDX_W-1:0] fall_o
);

   logic prev_pass;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         found_o     <= 1'b0;
         prev_pass   <= 1'b0;
         raise_set_o <= 1'b0;
         raise_o     <= '0;
         fall_set_o  <= 1'b0;
         fall_o      <= '0;
      end else if (clr_i) begin
         found_o     <= 1'b0;
         prev_pass   <= 1'b0;
         raise_set_o <= 1'b0;
         raise_o     <= '0;
         fall_set_o  <= 1'b0;
         fall_o      <= '0;
      end else if (upd_i) begin
         if (pass_i) found_o <= 1'b1;
         if (idx_i != '0) begin
            if (!pass_i && prev_pass) begin
               fall_set_o <= 1'b1;
               fall_o     <= idx_i - 1'b1;
            end
            if (pass_i && !prev_pass) begin
               raise_set_o <= 1'b1;
               raise_o     <= idx_i;
            end
         end
         prev_pass <= pass_i;
      end
   end

endmodule

// File: rtl/spt_center_pick.sv
module spt_center_pick #(
   parameter int IDX_W      = 3,
   parameter int NUM_PHASES = 8
) (
   input  logic             raise_set_i,
   input  logic [IDX_W-1:0] raise_i,
   input  logic             fall_set_i,
   input  logic [IDX_W-1:0] fall_i,
   output logic [IDX_W-1:0] pick_o
);

   localparam int SW = IDX_W + 1;
   localparam logic [SW-1:0] LAST_W = SW'(NUM_PHASES - 1);

   logic [SW-1:0] r, f, sum, mid;

   always_comb begin
      r   = raise_set_i ? {1'b0, raise_i} : '0;
      f   = fall_set_i  ? {1'b0, fall_i}  : LAST_W;
      sum = r + f;
      if (f >= r)
         mid = sum >> 1;
      else if (sum > LAST_W)
         mid = f >> 1;
      else
         mid = (r + LAST_W) >> 1;
      pick_o = mid[IDX_W-1:0];
   end

endmodule

// File: rtl/samp_phase_tuner.sv
module samp_phase_tuner #(
   parameter int NUM_PHASES = 8,
   parameter int CLR_W      = 17
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start_i,
   output logic                          busy_o,
   output logic                          done_o,
   output logic                          err_o,
   output logic [$clog2(NUM_PHASES)-1:0] phase_idx_o,
   output logic                          phase_vld_o,
   output logic                          clr_we_o,
   output logic [CLR_W-1:0]              clr_data_o,
   output logic                          tune_req_o,
   input  logic                          tune_ack_i,
   input  logic                          tune_pass_i
);
   import spt_pkg::*;

   localparam int IDX_W = $clog2(NUM_PHASES);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PHASES - 1);
   localparam logic [CLR_W-1:0] CLR_MASK = {CLR_W{1'b1}};

   if (NUM_PHASES < 2) begin : g_bad_phases
      $error("samp_phase_tuner: NUM_PHASES must be at least 2");
   end
   if (CLR_W < 1) begin : g_bad_clr
      $error("samp_phase_tuner: CLR_W must be at least 1");
   end

   spt_state_e       state;
   logic [IDX_W-1:0] idx;
   logic             found, raise_set, fall_set;
   logic [IDX_W-1:0] raise_pt, fall_pt, pick;
   logic             trk_clr, trk_upd;

   assign trk_clr = (state == ST_IDLE) && start_i;
   assign trk_upd = (state == ST_REQ) && tune_ack_i;

   spt_edge_track #(.IDX_W(IDX_W)) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (trk_clr),
      .upd_i       (trk_upd),
      .idx_i       (idx),
      .pass_i      (tune_pass_i),
      .found_o     (found),
      .raise_set_o (raise_set),
      .raise_o     (raise_pt),
      .fall_set_o  (fall_set),
      .fall_o      (fall_pt)
   );

   spt_center_pick #(.IDX_W(IDX_W), .NUM_PHASES(NUM_PHASES)) u_pick (
      .raise_set_i (raise_set),
      .raise_i     (raise_pt),
      .fall_set_i  (fall_set),
      .fall_i      (fall_pt),
      .pick_o      (pick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         idx   <= '0;
      end else begin
         case (state)
            ST_IDLE:   if (start_i) begin
                          idx   <= '0;
                          state <= ST_PHASE;
                       end
            ST_PHASE:  state <= ST_CLR;
            ST_CLR:    state <= ST_REQ;
            ST_REQ:    if (tune_ack_i) state <= ST_CHECK;
            ST_CHECK:  if ((raise_set && fall_set) || idx == LAST_IDX)
                          state <= ST_APPLY;
                       else begin
                          idx   <= idx + 1'b1;
                          state <= ST_PHASE;
                       end
            ST_APPLY:  state <= ST_ENDCLR;
            ST_ENDCLR: state <= ST_DONE;
            default:   state <= ST_IDLE;
         endcase
      end
   end

   assign busy_o      = (state != ST_IDLE);
   assign done_o      = (state == ST_DONE);
   assign err_o       = (state == ST_DONE) && !found;
   assign phase_vld_o = (state == ST_PHASE) || ((state == ST_APPLY) && found);
   assign phase_idx_o = (state == ST_APPLY) ? pick : idx;
   assign clr_we_o    = (state == ST_CLR) || (state == ST_ENDCLR);
   assign clr_data_o  = clr_we_o ? CLR_MASK : '0;
   assign tune_req_o  = (state == ST_REQ);

endmodule

module samp_phase_tuner_chk #(
   parameter int NUM_PHASES = 8,
   parameter int CLR_W      = 17
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          start_i,
   input logic                          busy_o,
   input logic                          done_o,
   input logic                          err_o,
   input logic [$clog2(NUM_PHASES)-1:0] phase_idx_o,
   input logic                          phase_vld_o,
   input logic                          clr_we_o,
   input logic [CLR_W-1:0]              clr_data_o,
   input logic                          tune_req_o,
   input logic                          tune_ack_i
);

   // R2
   req_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tune_req_o) |-> $past(clr_we_o));

   // R2
   strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({phase_vld_o, clr_we_o, tune_req_o, done_o}));

   // R2
   clear_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we_o |-> (clr_data_o == {CLR_W{1'b1}}));

   // R2
   phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phase_vld_o |-> (int'(phase_idx_o) < NUM_PHASES));

   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tune_req_o && !tune_ack_i) |=> tune_req_o);

   // R8
   err_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> done_o);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o));

   // R9
   done_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> busy_o);

   // R10
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !done_o) |=> busy_o);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !(phase_vld_o || clr_we_o || tune_req_o || done_o));

endmodule

bind samp_phase_tuner samp_phase_tuner_chk #(
   .NUM_PHASES (NUM_PHASES),
   .CLR_W      (CLR_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .err_o       (err_o),
   .phase_idx_o (phase_idx_o),
   .phase_vld_o (phase_vld_o),
   .clr_we_o    (clr_we_o),
   .clr_data_o  (clr_data_o),
   .tune_req_o  (tune_req_o),
   .tune_ack_i  (tune_ack_i)
);

// File: tb/test_samp_phase_tuner.sv
module test_samp_phase_tuner;

   localparam int NP = 8;
   localparam int CW = 17;
   localparam logic [CW-1:0] MASK = 17'h1FFFF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          busy, done, err, ph_vld, clr_we, tune_req;
   logic [2:0]    ph_idx;
   logic [CW-1:0] clr_data;
   logic          tune_ack = 1'b0;
   logic          tune_pass = 1'b0;

   always #2 clk = ~clk;

   samp_phase_tuner i_samp_phase_tuner (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .busy_o      (busy),
      .done_o      (done),
      .err_o       (err),
      .phase_idx_o (ph_idx),
      .phase_vld_o (ph_vld),
      .clr_we_o    (clr_we),
      .clr_data_o  (clr_data),
      .tune_req_o  (tune_req),
      .tune_ack_i  (tune_ack),
      .tune_pass_i (tune_pass)
   );

   int          n_chk = 0;
   int          n_fail = 0;
   int          exp_q[$];
   string       tag = "R1";
   logic [NP-1:0] pattern = '0;
   int          ack_lat = 0;
   int          cur_ph = 0;
   logic        req_seen = 1'b0;
   logic        done_seen = 1'b0;

   // Event codes: 100+i phase strobe, 200 clear with all-ones mask
   // (201 wrong mask), 300+i request at phase i, 400+err done.
   task automatic sb_cmp(input int got);
      int want;
      n_chk++;
      if (exp_q.size() == 0) begin
         n_fail++;
         $display("FAIL %s: unexpected event %0d, expected none", tag, got);
      end else begin
         want = exp_q.pop_front();
         if (got != want) begin
            n_fail++;
            $display("FAIL %s: event %0d, expected %0d", tag, got, want);
         end
      end
   endtask

   task automatic check(input string rq, input int got, input int want);
      n_chk++;
      if (got != want) begin
         n_fail++;
         $display("FAIL %s: got %0d, expected %0d", rq, got, want);
      end
   endtask

   // Monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (ph_vld) begin
            cur_ph = int'(ph_idx);
            sb_cmp(100 + int'(ph_idx));
         end
         if (clr_we) sb_cmp((clr_data == MASK) ? 200 : 201);
         if (tune_req && !req_seen) sb_cmp(300 + cur_ph);
         req_seen = tune_req;
         if (done) begin
            sb_cmp(400 + int'(err));
            done_seen = 1'b1;
         end
      end
   end

   // Tuning engine model
   initial begin
      forever begin
         @(negedge clk);
         if (tune_req && !tune_ack) begin
            repeat (ack_lat) @(negedge clk);
            tune_ack  = 1'b1;
            tune_pass = pattern[cur_ph];
            @(negedge clk);
            tune_ack  = 1'b0;
            tune_pass = 1'b0;
         end
      end
   end

   // Driver: expected event list from the requirements
   task automatic push_expected(input logic [NP-1:0] p);
      int  r = 0, f = NP - 1, pick;
      bit  fnd = 0, prev = 0, rs = 0, fs = 0, ps;
      for (int i = 0; i < NP; i++) begin
         exp_q.push_back(100 + i);
         exp_q.push_back(200);
         exp_q.push_back(300 + i);
         ps = p[i];
         if (ps) fnd = 1;
         if (i > 0) begin
            if (!ps && prev) begin fs = 1; f = i - 1; end
            if (ps && !prev) begin rs = 1; r = i; end
         end
         if (rs && fs) break;
         prev = ps;
      end
      if (fnd) begin
         if (f >= r) pick = (r + f) / 2;
         else if (r + f > NP - 1) pick = f / 2;
         else pick = (r + NP - 1) / 2;
         exp_q.push_back(100 + pick);
      end
      exp_q.push_back(200);
      exp_q.push_back(fnd ? 400 : 401);
   endtask

   task automatic run(input string t, input logic [NP-1:0] p, input int lat);
      int guard = 0;
      tag       = t;
      pattern   = p;
      ack_lat   = lat;
      done_seen = 1'b0;
      push_expected(p);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check({t, " busy after start"}, int'(busy), 1);
      repeat (4) @(negedge clk);
      start = 1'b1;          // R10: ignored while busy
      @(negedge clk);
      start = 1'b0;
      while (!done_seen && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      @(negedge clk);
      check({t, " R9 busy low after done"}, int'(busy), 0);
      check({t, " R5 no missing events"}, exp_q.size(), 0);
      exp_q.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 busy", int'(busy), 0);
      check("R1 done", int'(done), 0);
      check("R1 err", int'(err), 0);
      check("R1 strobes", int'({ph_vld, clr_we, tune_req}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 idle after reset", int'({busy, ph_vld, clr_we, tune_req}), 0);

      run("R2/R6 all pass", 8'hFF, 0);
      run("R8 all fail", 8'h00, 1);
      run("R4/R5/R6 middle window", 8'h3C, 2);
      run("R7 wrap short", 8'hC3, 0);
      run("R7 wrap long", 8'h8F, 3);
      run("R6 single last", 8'h80, 1);
      run("R6 single first", 8'h01, 0);
      run("R3/R4/R5 single inner", 8'h02, 3);
      run("R10 restart clears edges", 8'hF0, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule